// File: doc/BRIEF.md
# I2C Serial Memory Slave with Supervisor Gating

This block is the bus-facing half of a 4096-byte serial memory. It sits on a two-wire I2C bus as a slave. The system clock oversamples the bus lines, and the block drives SDA only through an open-drain pull-down enable. A master selects the device with a 7-bit address. That address is a fixed 4-bit family code followed by three strap inputs, so eight of these devices can share one bus. The master then supplies a 12-bit memory pointer as two bytes and either streams up to a page of data in or reads any number of bytes out. The storage is a plain register array.

Written bytes first collect in a 64-byte page buffer. Nothing reaches the array until the master closes the transfer with a STOP. The STOP launches an internal program cycle that lasts a fixed number of clocks. During that cycle the buffer drains into the array, and the slave ignores its own address, so a master polls it to learn when the cycle has ended.

A `reset_active` input from a supply supervisor overrides the bus side. It aborts any transfer in flight, discards data that has not been committed, refuses new transfers and prevents a program cycle from starting. A program cycle that is already running always runs to completion.

Top module: `i2c_mem_slave`

## Requirements
- R1: A device address byte whose upper seven bits equal 1010 followed by `strap[2:1:0]` (MSB first, R/W in bit 0) is acknowledged by pulling SDA low in the ninth clock. Any other address byte is not acknowledged and SDA stays released.
- R2: After a write-addressed device byte, the next two bytes form the pointer, high byte first. Only the low 4 bits of the high byte are used, and its upper 4 bits are ignored.
- R3: Data bytes of a write land at successive addresses whose low 6 bits wrap inside the same 64-byte page. The array changes only after the STOP that ends the transfer.
- R4: A write transfer that is ended by a repeated START, and not by a STOP, leaves the array unchanged.
- R5: After a STOP that ends a write with at least one data byte, the slave runs a program cycle of exactly `WC_CYCLES` clocks. During that cycle it does not acknowledge its address and keeps SDA released. After the cycle it acknowledges again.
- R6: A random read (pointer write, repeated START, read-addressed device byte) returns the byte at the pointer. A current-address read continues from the address after the last byte transferred.
- R7: A sequential read returns successive addresses and rolls over from 4095 to 0.
- R8: A master NACK after a read byte ends the read. The slave then drives SDA for no further clock until the next START.
- R9: When `reset_active` rises during a transfer, SDA is released on the following clock, and the data bytes received so far are never written.
- R10: While `reset_active` is high, a device address byte is not acknowledged.
- R11: A STOP that arrives while `reset_active` is high starts no program cycle. The slave acknowledges its address as soon as `reset_active` falls.
- R12: A program cycle already running when `reset_active` rises completes, and its data is stored.
- R13: After the synchronous reset `rst_n`, SDA is released and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired level) |
| strap | input | 3 | Hardware address straps, tie low when unused |
| reset_active | input | 1 | Supply supervisor reset indication, active high |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The hardest state to reach from the ports is one where the supervisor asserts while the slave itself holds SDA low, or while a program cycle is still draining. The bench times `reset_active` inside the acknowledge slot of a data byte, where the slave is driving. It also raises `reset_active` a few clocks after a write STOP, so the program cycle is already under way. Both cases are then observed purely through later address acknowledges and read-back data. Page wrap, rollover at the top address and writes cut off by a repeated START are set up by directed transfers. Seeded random page writes and reads cover the rest against a bench-side memory model.

// File: rtl/i2cm_pkg.sv
// Shared constants and types of the I2C memory slave.
package i2cm_pkg;
    // Fixed family code in the upper four bits of the device address byte.
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // Bit/byte-level states of the bus link.
    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RX_ACK,
        LK_TX,
        LK_TX_ACK,
        LK_TX_NEXT
    } link_state_t;

    // Meaning of the next byte received from the master.
    typedef enum logic [1:0] {
        BK_DEV,
        BK_AHI,
        BK_ALO,
        BK_DATA
    } byte_kind_t;
endpackage

// File: rtl/i2cm_bus_sync.sv
// Bus line synchronizer and condition detector.
// Brings SCL/SDA into the clk domain through STAGES flops. It then flags SCL edges,
// START (SDA falls while SCL high) and STOP (SDA rises while SCL high).
// Assumes clk is several times faster than SCL. Lines reset to the idle (high) level.
module i2cm_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Shift both lines through the synchronizer chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cm_link.sv
// Bus link: byte shifting, address decode, acknowledge and read data drive.
// Receives bytes on SCL rises and acts on them at the following SCL fall. It drives SDA
// only after a fall. A pointer write selects the memory address. Write data goes out as
// buffer pulses, and a STOP after buffered data raises a one-clock commit request.
// reset_active overrides everything. Assumes single-cycle condition pulses from the sync.
module i2cm_link
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic              reset_active,
    input  logic              wc_busy,
    input  logic [7:0]        mem_rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] ptr,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              buf_clear,
    output logic              commit
);
    localparam int HI_W = ADDR_W - 8;

    link_state_t     state;
    byte_kind_t      kind;
    logic [3:0]      bit_cnt;
    logic [7:0]      shreg;
    logic            rw;
    logic            pending;
    logic [HI_W-1:0] ptr_hi;

    // Protocol sequencer: supervisor abort, then START/STOP, then bit-level handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LK_IDLE;
            kind      <= BK_DEV;
            bit_cnt   <= '0;
            shreg     <= '0;
            rw        <= 1'b0;
            pending   <= 1'b0;
            ptr_hi    <= '0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
            buf_clear <= 1'b0;
            commit    <= 1'b0;
        end else begin
            buf_we    <= 1'b0;
            buf_clear <= 1'b0;
            commit    <= 1'b0;
            if (reset_active) begin
                state     <= LK_IDLE;
                sda_oe    <= 1'b0;
                pending   <= 1'b0;
                buf_clear <= 1'b1;
            end else if (start_det) begin
                state     <= LK_RX;
                kind      <= BK_DEV;
                bit_cnt   <= '0;
                rw        <= 1'b0;
                sda_oe    <= 1'b0;
                pending   <= 1'b0;
                buf_clear <= 1'b1;
            end else if (stop_det) begin
                state   <= LK_IDLE;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
                commit  <= pending;
            end else begin
                case (state)
                    LK_RX: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            case (kind)
                                BK_DEV: begin
                                    if (shreg[7:1] == {DEV_CODE, strap} && !wc_busy) begin
                                        sda_oe <= 1'b1;
                                        rw     <= shreg[0];
                                        kind   <= BK_AHI;
                                        state  <= LK_RX_ACK;
                                    end else begin
                                        state <= LK_IDLE;
                                    end
                                end
                                BK_AHI: begin
                                    ptr_hi <= shreg[HI_W-1:0];
                                    sda_oe <= 1'b1;
                                    kind   <= BK_ALO;
                                    state  <= LK_RX_ACK;
                                end
                                BK_ALO: begin
                                    ptr    <= {ptr_hi, shreg};
                                    sda_oe <= 1'b1;
                                    kind   <= BK_DATA;
                                    state  <= LK_RX_ACK;
                                end
                                default: begin
                                    buf_we              <= 1'b1;
                                    buf_addr            <= ptr;
                                    buf_wdata           <= shreg;
                                    ptr[PAGE_W-1:0]     <= ptr[PAGE_W-1:0] + 1'b1;
                                    pending             <= 1'b1;
                                    sda_oe              <= 1'b1;
                                    state               <= LK_RX_ACK;
                                end
                            endcase
                        end
                    end
                    LK_RX_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg   <= mem_rdata;
                                sda_oe  <= ~mem_rdata[7];
                                bit_cnt <= 4'd1;
                                state   <= LK_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= LK_RX;
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt != 4'd8) begin
                                sda_oe  <= ~shreg[6];
                                shreg   <= {shreg[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= LK_TX_ACK;
                            end
                        end
                    end
                    LK_TX_ACK: begin
                        if (scl_rise) begin
                            state <= sda_s ? LK_IDLE : LK_TX_NEXT;
                        end
                    end
                    LK_TX_NEXT: begin
                        if (scl_fall) begin
                            shreg   <= mem_rdata;
                            sda_oe  <= ~mem_rdata[7];
                            bit_cnt <= 4'd1;
                            state   <= LK_TX;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cm_page_prog.sv
// Page buffer and program-cycle engine.
// Collects write bytes for one page with a per-byte valid mask. On commit (refused while
// reset_active is high) it runs busy for exactly WC_CYCLES clocks. In the first PAGE_BYTES
// of those clocks it drains one buffer slot per clock into the array. Clears are ignored
// while busy, so a running cycle cannot be cut short. Assumes WC_CYCLES >= 2**PAGE_W.
module i2cm_page_prog #(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 6,
    parameter int WC_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_active,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    input  logic              buf_clear,
    input  logic              commit,
    output logic              wc_busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(WC_CYCLES + 1);
    localparam int SEL_W      = ADDR_W - PAGE_W;

    logic [7:0]            page_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [SEL_W-1:0]      page_sel;
    logic [CNT_W-1:0]      timer;
    logic [PAGE_W:0]       idx;

    // Buffer data storage: capture bytes only outside a program cycle.
    always_ff @(posedge clk) begin
        if (buf_we && !wc_busy) begin
            page_data[buf_addr[PAGE_W-1:0]] <= buf_wdata;
        end
    end

    // Cycle control: run timer and drain index, or accept commit/clear/byte marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= '0;
            page_sel <= '0;
            timer    <= '0;
            idx      <= '0;
            wc_busy  <= 1'b0;
        end else if (wc_busy) begin
            timer <= timer + 1'b1;
            if (!idx[PAGE_W]) begin
                idx <= idx + 1'b1;
            end
            if (timer == CNT_W'(WC_CYCLES - 1)) begin
                wc_busy <= 1'b0;
                valid   <= '0;
            end
        end else if (commit && !reset_active) begin
            wc_busy <= 1'b1;
            timer   <= '0;
            idx     <= '0;
        end else if (buf_clear) begin
            valid <= '0;
        end else if (buf_we) begin
            valid[buf_addr[PAGE_W-1:0]] <= 1'b1;
            page_sel                    <= buf_addr[ADDR_W-1:PAGE_W];
        end
    end

    assign mem_we    = wc_busy && !idx[PAGE_W] && valid[idx[PAGE_W-1:0]];
    assign mem_waddr = {page_sel, idx[PAGE_W-1:0]};
    assign mem_wdata = page_data[idx[PAGE_W-1:0]];
endmodule

// File: rtl/i2cm_mem_store.sv
// Byte array standing in for the memory cells: one synchronous write port and one
// combinational read port. Contents are not reset; only written locations are defined.
module i2cm_mem_store #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Cell update from the program engine.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_mem_slave.sv
// Top level: I2C memory slave gated by a supply supervisor.
// Chains the line synchronizer, the bus link, the page/program engine and the byte array.
// Assumes clk oversamples SCL by at least 8x, and that the pad drives SDA low when
// sda_oe is high.
module i2c_mem_slave #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 6,
    parameter int WC_CYCLES   = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    input  logic       reset_active,
    output logic       sda_oe
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wc_busy;
    logic [7:0]        mem_rdata;
    logic [ADDR_W-1:0] ptr;
    logic              buf_we;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_wdata;
    logic              buf_clear;
    logic              commit;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    i2cm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_link #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .strap        (strap),
        .reset_active (reset_active),
        .wc_busy      (wc_busy),
        .mem_rdata    (mem_rdata),
        .sda_oe       (sda_oe),
        .ptr          (ptr),
        .buf_we       (buf_we),
        .buf_addr     (buf_addr),
        .buf_wdata    (buf_wdata),
        .buf_clear    (buf_clear),
        .commit       (commit)
    );

    i2cm_page_prog #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) u_prog (
        .clk          (clk),
        .rst_n        (rst_n),
        .reset_active (reset_active),
        .buf_we       (buf_we),
        .buf_addr     (buf_addr),
        .buf_wdata    (buf_wdata),
        .buf_clear    (buf_clear),
        .commit       (commit),
        .wc_busy      (wc_busy),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata)
    );

    i2cm_mem_store #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/i2cm_slave_chk.sv
// Assertion checker for i2c_mem_slave, attached by bind. It measures the length of each
// program cycle with its own counter.
module i2cm_slave_chk #(
    parameter int WC_CYCLES = 300
) (
    input logic clk,
    input logic rst_n,
    input logic reset_active,
    input logic sda_oe,
    input logic wc_busy,
    input logic mem_we
);
    localparam int CNT_W = $clog2(WC_CYCLES + 2);

    logic [CNT_W-1:0] run_len;

    // Count consecutive busy clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (wc_busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |=> !sda_oe);

    a_r5_silent_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wc_busy |-> !sda_oe);

    a_r11_no_start_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc_busy) |-> !$past(reset_active));

    a_r12_full_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wc_busy) |-> run_len == CNT_W'(WC_CYCLES));

    a_r3_store_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wc_busy);
endmodule

bind i2c_mem_slave i2cm_slave_chk #(.WC_CYCLES(WC_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_active (reset_active),
    .sda_oe       (sda_oe),
    .wc_busy      (wc_busy),
    .mem_we       (mem_we)
);

// File: tb/i2c_mem_slave_tb.sv
// Bench for i2c_mem_slave: bit-banged bus master, bench-side memory model,
// directed corner cases plus seeded random page writes and reads.
module i2c_mem_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int WC         = 300;
    localparam int DEPTH      = 4096;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic reset_active = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_slave #(.WC_CYCLES(WC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_line),
        .strap        (STRAP),
        .reset_active (reset_active),
        .sda_oe       (sda_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;
    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    int         pend_addr [64];
    logic [7:0] pend_data [64];
    int         pend_n = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] devb(logic [2:0] s, bit rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bits(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
        end
        sda_m = 1'b1;
    endtask

    task automatic send_byte(logic [7:0] b, output bit acked);
        send_bits(b);
        wt(H); scl = 1'b1; wt(H / 2); acked = !sda_line; wt(H - H / 2); scl = 1'b0; wt(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl = 1'b1; wt(H / 2); b[i] = sda_line; wt(H - H / 2); scl = 1'b0; wt(2);
        end
        sda_m = ack ? 1'b0 : 1'b1;
        wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    // Write transfer without STOP; queued bytes go to the model at commit_model.
    task automatic write_open(int a16, int n, output bit all_ack);
        bit ak;
        int a;
        logic [7:0] d;
        all_ack = 1'b1;
        pend_n = 0;
        a = a16 & (DEPTH - 1);
        bus_start();
        send_byte(devb(STRAP, 1'b0), ak); all_ack &= ak;
        send_byte(8'(a16 >> 8), ak); all_ack &= ak;
        send_byte(8'(a16), ak); all_ack &= ak;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ak); all_ack &= ak;
            pend_addr[pend_n] = (a & ~63) | ((a + i) & 63);
            pend_data[pend_n] = d;
            pend_n++;
        end
    endtask

    function automatic void commit_model();
        for (int i = 0; i < pend_n; i++) begin
            model[pend_addr[i]] = pend_data[i];
            known[pend_addr[i]] = 1'b1;
        end
        pend_n = 0;
    endfunction

    // Random read of n bytes from addr, checked against the model where defined.
    task automatic read_check(int addr, int n, string req);
        bit ak;
        logic [7:0] b;
        int a;
        bus_start();
        send_byte(devb(STRAP, 1'b0), ak);
        send_byte(8'(addr >> 8), ak);
        send_byte(8'(addr), ak);
        bus_start();
        send_byte(devb(STRAP, 1'b1), ak);
        chk(ak, {req, " read address ack"}, int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            a = (addr + i) & (DEPTH - 1);
            if (known[a]) chk(b == model[a], req, int'(b), int'(model[a]));
        end
        bus_stop();
    endtask

    task automatic probe_addr(output bit acked);
        bus_start();
        send_byte(devb(STRAP, 1'b0), acked);
        bus_stop();
    endtask

    initial begin
        bit ak;
        logic [7:0] b;
        int a;
        int n;
        void'($urandom(32'h5EED));
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        chk(sda_oe == 1'b0, "R13 reset releases SDA", int'(sda_oe), 0);

        // R1: wrong strap is not acknowledged, SDA stays released
        bus_start();
        send_byte(devb(3'b011, 1'b0), ak);
        chk(!ak, "R1 foreign address nack", int'(ak), 0);
        bus_stop();
        probe_addr(ak);
        chk(ak, "R1 own address ack", int'(ak), 1);

        // R2 + R3: byte write with junk upper nibble, read back at the masked address
        write_open(16'hF123, 1, ak);
        chk(ak, "R2 pointer bytes acked", int'(ak), 1);
        bus_stop(); commit_model();
        wt(WC + 60);
        read_check(12'h123, 1, "R2 upper nibble ignored");

        // R3: page write wrapping from offset 60 to offset 3 of the same page
        write_open(12'h2BC, 8, ak);
        bus_stop(); commit_model();
        // R5: address refused during the program cycle
        probe_addr(ak);
        chk(!ak, "R5 busy nack", int'(ak), 0);
        wt(WC + 60);
        probe_addr(ak);
        chk(ak, "R5 ack after cycle", int'(ak), 1);
        read_check(12'h2BC, 4, "R3 page tail");
        read_check(12'h280, 4, "R3 page wrap head");
        chk(known[12'h2C0] == 1'b0, "R3 next page untouched in model", int'(known[12'h2C0]), 0);

        // R4: write cut by a repeated START leaves old data
        write_open(12'h2BC, 2, ak);
        pend_n = 0;
        read_check(12'h2BC, 2, "R4 repeated start discards");

        // R6: current-address read continues after the last byte
        read_check(12'h280, 2, "R6 random read");
        bus_start();
        send_byte(devb(STRAP, 1'b1), ak);
        recv_byte(b, 1'b0);
        chk(b == model[12'h282], "R6 current address read", int'(b), int'(model[12'h282]));
        // R8: after master NACK the slave stays off the bus for further clocks
        for (int i = 0; i < 9; i++) begin
            wt(H); scl = 1'b1; wt(H / 2);
            if (i == 0 || i == 8) chk(sda_oe == 1'b0, "R8 silent after nack", int'(sda_oe), 0);
            wt(H - H / 2); scl = 1'b0; wt(2);
        end
        bus_stop();

        // R7: sequential read rolls from the top address to zero
        write_open(12'hFFF, 1, ak); bus_stop(); commit_model(); wt(WC + 60);
        write_open(12'h000, 1, ak); bus_stop(); commit_model(); wt(WC + 60);
        read_check(12'hFFF, 2, "R7 rollover");

        // R9: supervisor asserts while the slave acknowledges a data byte
        write_open(12'h123, 1, ak);
        pend_n = 0;
        send_bits(8'h5A);
        wt(H); scl = 1'b1; wt(H / 2);
        chk(sda_oe == 1'b1, "R9 slave acking before abort", int'(sda_oe), 1);
        reset_active = 1'b1;
        wt(2);
        chk(sda_oe == 1'b0, "R9 abort releases SDA", int'(sda_oe), 0);
        wt(H - H / 2); scl = 1'b0; wt(2);
        // R10: address refused while reset is active
        bus_start();
        send_byte(devb(STRAP, 1'b0), ak);
        chk(!ak, "R10 nack under reset", int'(ak), 0);
        // R11: STOP under reset starts no program cycle
        bus_stop();
        reset_active = 1'b0;
        wt(4);
        probe_addr(ak);
        chk(ak, "R11 no cycle after stop in reset", int'(ak), 1);
        read_check(12'h123, 1, "R9 aborted data not stored");

        // R12: program cycle survives a supervisor reset
        write_open(12'h456, 3, ak);
        bus_stop(); commit_model();
        wt(10);
        reset_active = 1'b1;
        wt(50);
        reset_active = 1'b0;
        wt(WC + 60);
        read_check(12'h456, 3, "R12 running cycle completes");

        // Seeded random page writes and reads (R3, R6, R7)
        for (int it = 0; it < 12; it++) begin
            a = int'($urandom % DEPTH);
            n = 1 + int'($urandom % 12);
            write_open(a, n, ak);
            chk(ak, "R3 random write acked", int'(ak), 1);
            bus_stop(); commit_model();
            wt(WC + 60);
            read_check(a & ~63, 64 < n + 2 ? 64 : (a & 63) + n + 1, "R3 random page readback");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 190000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule